// File: doc/BRIEF.md
# I2C memory transaction sequencer

This block runs whole transactions against register-addressed I2C targets such as serial EEPROMs. It sits on top of a bit-level bus engine, which handles timing. A request names the operation (probe, read or write), a 7-bit target address, an internal address of up to four bytes with its length (0 to 4), and a byte count. The sequencer then issues start, stop, byte-write and byte-read commands to the engine, one at a time. For each command it waits for the engine's completion pulse, which carries the acknowledge bit or the received byte.

Write payload comes in on a valid/ready byte stream, and received bytes go out on another one. When the transaction ends, the block pulses `done` and holds a status until the next request. The status reports either that the target did not answer, that an internal address byte was refused, or how many payload bytes were refused. Two options apply to a transaction. The first picks the turnaround between the address phase and the read phase: either a stop and then a start, or a repeated start. The second folds the internal address bits that lie above the sent address bytes into the target address, through a mask.

Top module: `i2c_txn_seq`

## Requirements
- R1: A probe (req_op 0 or 3) issues start, a write of {dev,0}, then stop. st_nodev is 1 exactly when that byte was refused (engine nack = 1).
- R2: For a write (req_op 2), or for a read (req_op 1) with nonzero address length, the first byte after start is {dev,0}. If it is refused, a stop follows at once, st_nodev is set, and the transaction ends.
- R3: Internal address bytes are written most significant first. Exactly req_alen of them are sent, taken from the low req_alen bytes of req_addr. Lengths above 4 act as 4.
- R4: A refused internal address byte is followed at once by a stop. st_anack is then set and st_nodev is cleared.
- R5: For a read with nonzero address length, cfg_rep_start=0 puts a stop and then a start after the last address byte. cfg_rep_start=1 puts a start alone there.
- R6: A read with req_alen=0 goes directly from the first start to the write of {dev,1}.
- R7: The read phase writes {dev,1}, then issues req_len read commands, then a stop. The cmd_nak bit is 0 on every read command except the last, where it is 1, and it is 0 on all other commands.
- R8: With cfg_ovf_en=1, reads and writes OR into dev the value (req_addr >> 8*req_alen) & cfg_ovf_mask, taking its low 7 bits. Probes are never modified.
- R9: In a write, each of the req_len payload bytes is taken from the write stream and sent, whatever the earlier acks were. A stop follows, and st_fails equals the number of refused payload bytes.
- R10: `done` pulses for one cycle after the final stop completes, with busy low. The status holds until the next accepted request.
- R11: busy is 0 after reset and rises the cycle after a request is accepted in idle. A req_valid seen while busy is ignored, and no command is issued while idle.
- R12: Received bytes appear on rd_data in arrival order. Each byte is held, with rd_valid high, until rd_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 probe, 1 read, 2 write, 3 probe |
| req_dev | input | 7 | Target address |
| req_addr | input | 8*ADDR_BYTES | Internal address |
| req_alen | input | ALW | Internal address length in bytes |
| req_len | input | LEN_W | Payload byte count |
| cfg_rep_start | input | 1 | 1: repeated start before read phase |
| cfg_ovf_en | input | 1 | Enable address-overflow folding |
| cfg_ovf_mask | input | 7 | Mask for folded bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| st_nodev | output | 1 | Target did not answer |
| st_anack | output | 1 | Internal address byte refused |
| st_fails | output | LEN_W | Refused payload bytes |
| cmd_valid | output | 1 | Command to engine valid |
| cmd_ready | input | 1 | Engine takes command |
| cmd_op | output | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_data | output | 8 | Byte to write (0 otherwise) |
| cmd_nak | output | 1 | Send no-ack after this read byte |
| eng_done | input | 1 | Engine finished the accepted command |
| eng_nack | input | 1 | Written byte was refused |
| eng_rdata | input | 8 | Byte received by a read command |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Received byte valid |
| rd_ready | input | 1 | Received byte taken |
| rd_data | output | 8 | Received byte |

## Verification
The bench compares every command the block issues with a command list it derives itself from the request and from a chosen pattern of refused bytes.

Probes with a present and an absent target separate the acknowledge decision from the plain sequencing. Reads with two-byte, one-byte and zero-length addresses, under both turnaround settings, show the address-phase branches and which turnaround was picked. Refusals placed on the target byte, on the second address byte and on individual payload bytes show abort from count-and-continue. A folded overflow address, a four-byte address with folding enabled, and a second request issued mid-transaction check the address fold and the busy gate.

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
  parameter int LEN_W      = 8,
  parameter int ADDR_BYTES = 4,
  localparam int AW  = 8 * ADDR_BYTES,
  localparam int ALW = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [6:0]       req_dev,
  input  logic [AW-1:0]    req_addr,
  input  logic [ALW-1:0]   req_alen,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cfg_rep_start,
  input  logic             cfg_ovf_en,
  input  logic [6:0]       cfg_ovf_mask,
  output logic             busy,
  output logic             done,
  output logic             st_nodev,
  output logic             st_anack,
  output logic [LEN_W-1:0] st_fails,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_nak,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rdata,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data
);

  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WR = 2'd2, C_RD = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_START1, S_DEVW, S_ADDR, S_TSTOP, S_START2, S_DEVR, S_RDATA, S_WDATA, S_STOP
  } phase_t;

  phase_t           ph, nxt_addr_done;
  logic             issued, rep_r, rd_v;
  logic [1:0]       op_r;
  logic [6:0]       dev_r, fold;
  logic [AW-1:0]    addr_r;
  logic [ALW-1:0]   alen_left, alen_c, alen_m1;
  logic [LEN_W-1:0] len_left, fails;
  logic [7:0]       addr_byte, rd_buf;
  logic             is_rd, is_wr, step, last_len;

  assign is_rd    = (op_r == 2'd1);
  assign is_wr    = (op_r == 2'd2);
  assign busy     = (ph != S_IDLE);
  assign step     = issued && eng_done;
  assign last_len = (len_left == LEN_W'(1));

  assign alen_c  = (req_alen > ALW'(ADDR_BYTES)) ? ALW'(ADDR_BYTES) : req_alen;
  assign fold    = (cfg_ovf_en && (req_op == 2'd1 || req_op == 2'd2))
                 ? (7'({8'b0, req_addr} >> {alen_c, 3'b000}) & cfg_ovf_mask) : 7'd0;
  assign alen_m1   = alen_left - ALW'(1);
  assign addr_byte = 8'(addr_r >> {alen_m1, 3'b000});

  assign cmd_valid = busy && !issued && !(ph == S_WDATA && !wr_valid) && !(ph == S_RDATA && rd_v);
  assign wr_ready  = (ph == S_WDATA) && !issued && cmd_ready;
  assign cmd_nak   = (ph == S_RDATA) && last_len;
  assign rd_valid  = rd_v;
  assign rd_data   = rd_buf;
  assign st_fails  = fails;

  always_comb begin
    cmd_op   = C_WR;
    cmd_data = 8'd0;
    case (ph)
      S_START1, S_START2: cmd_op = C_START;
      S_TSTOP, S_STOP:    cmd_op = C_STOP;
      S_RDATA:            cmd_op = C_RD;
      S_DEVW:             cmd_data = {dev_r, 1'b0};
      S_DEVR:             cmd_data = {dev_r, 1'b1};
      S_ADDR:             cmd_data = addr_byte;
      S_WDATA:            cmd_data = wr_data;
      default:            cmd_data = 8'd0;
    endcase
  end

  always_comb begin
    if (is_rd)             nxt_addr_done = rep_r ? S_START2 : S_TSTOP;
    else if (len_left != 0) nxt_addr_done = S_WDATA;
    else                   nxt_addr_done = S_STOP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= S_IDLE;
      issued    <= 1'b0;
      rep_r     <= 1'b0;
      op_r      <= 2'd0;
      dev_r     <= 7'd0;
      addr_r    <= '0;
      alen_left <= '0;
      len_left  <= '0;
      fails     <= '0;
      st_nodev  <= 1'b0;
      st_anack  <= 1'b0;
      rd_v      <= 1'b0;
      rd_buf    <= 8'd0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_v && rd_ready) rd_v <= 1'b0;
      if (cmd_valid && cmd_ready) issued <= 1'b1;

      if (ph == S_IDLE && req_valid) begin
        ph        <= S_START1;
        op_r      <= req_op;
        dev_r     <= req_dev | fold;
        addr_r    <= req_addr;
        alen_left <= alen_c;
        len_left  <= req_len;
        rep_r     <= cfg_rep_start;
        fails     <= '0;
        st_nodev  <= 1'b0;
        st_anack  <= 1'b0;
      end

      if (step) begin
        issued <= 1'b0;
        case (ph)
          S_START1: ph <= (is_rd && alen_left == 0) ? S_DEVR : S_DEVW;
          S_DEVW: begin
            if (eng_nack) begin
              st_nodev <= 1'b1;
              ph       <= S_STOP;
            end else if (!is_rd && !is_wr) ph <= S_STOP;
            else if (alen_left != 0)       ph <= S_ADDR;
            else                           ph <= nxt_addr_done;
          end
          S_ADDR: begin
            if (eng_nack) begin
              st_anack <= 1'b1;
              ph       <= S_STOP;
            end else begin
              alen_left <= alen_m1;
              if (alen_left == ALW'(1)) ph <= nxt_addr_done;
            end
          end
          S_TSTOP:  ph <= S_START2;
          S_START2: ph <= S_DEVR;
          S_DEVR:   ph <= (len_left != 0) ? S_RDATA : S_STOP;
          S_RDATA: begin
            rd_buf   <= eng_rdata;
            rd_v     <= 1'b1;
            len_left <= len_left - LEN_W'(1);
            if (last_len) ph <= S_STOP;
          end
          S_WDATA: begin
            fails    <= fails + LEN_W'(eng_nack);
            len_left <= len_left - LEN_W'(1);
            if (last_len) ph <= S_STOP;
          end
          S_STOP: begin
            ph   <= S_IDLE;
            done <= 1'b1;
          end
          default: ph <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       st_nodev,
  input logic       st_anack,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       cmd_nak,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_status_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(st_nodev && st_anack));

  p_nak_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_nak |-> cmd_op == 2'd3);

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (.*);

// File: tb/tb_i2c_txn_seq.sv
`timescale 1ns/1ps
module tb_i2c_txn_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, cfg_rep_start = 0, cfg_ovf_en = 0;
  logic [1:0] req_op = 0;
  logic [6:0] req_dev = 0, cfg_ovf_mask = 0;
  logic [31:0] req_addr = 0;
  logic [2:0] req_alen = 0;
  logic [7:0] req_len = 0;
  logic busy, done, st_nodev, st_anack, cmd_valid, cmd_nak, wr_ready, rd_valid;
  logic [7:0] st_fails, cmd_data, rd_data;
  logic [1:0] cmd_op;
  logic cmd_ready = 1, eng_done = 0, eng_nack = 0, wr_valid = 0, rd_ready = 1;
  logic [7:0] eng_rdata = 0, wr_data = 0;

  i2c_txn_seq dut (.*);

  int checks = 0, fails = 0;
  logic [10:0] exp_q[$];
  logic [7:0]  rdx_q[$];
  logic [7:0]  wr_q[$];
  logic [31:0] nack_bits = 0;
  int wcount = 0, rcount = 0;
  bit pend = 0, pend_wr = 0, pend_rd = 0, pop_wr = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 0;
      if (pend) begin
        if (pop_wr) begin
          void'(wr_q.pop_front());
          pop_wr = 0;
          wr_valid = wr_q.size() > 0;
          wr_data = wr_valid ? wr_q[0] : 8'h00;
        end
        eng_nack = pend_wr ? nack_bits[wcount] : 1'b0;
        if (pend_wr) wcount++;
        eng_rdata = pend_rd ? 8'(8'hA0 + rcount) : 8'h00;
        if (pend_rd) rcount++;
        eng_done = 1;
        pend = 0;
      end else if (rst_n && cmd_valid) begin
        logic [10:0] got;
        got = {cmd_op, cmd_data, cmd_nak};
        if (exp_q.size() == 0) chk(0, "R3", "unexpected command", int'(got), 0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R3/R5/R7", "command {op,data,nak}", int'(got), int'(e));
        end
        if (wr_ready && wr_valid) pop_wr = 1;
        pend = 1;
        pend_wr = (cmd_op == 2'd2);
        pend_rd = (cmd_op == 2'd3);
      end
      if (rd_valid && rd_ready) begin
        if (rdx_q.size() == 0) chk(0, "R12", "unexpected read byte", int'(rd_data), 0);
        else begin
          logic [7:0] e;
          e = rdx_q.pop_front();
          chk(rd_data == e, "R12", "read byte", int'(rd_data), int'(e));
        end
      end
    end
  end

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic nk);
    exp_q.push_back({op, d, nk});
  endtask

  // driver: builds the expected command list, then issues the request
  task automatic run(input logic [1:0] op, input logic [6:0] dev, input logic [31:0] addr,
                     input int alen, input int len, input bit rep, input bit ovf,
                     input logic [6:0] mask, input logic [31:0] nb, input bit intrude,
                     input string tag);
    int w = 0, e_f = 0, k = 0;
    bit e_nod = 0, e_an = 0, stop_now = 0;
    logic [6:0] d;
    logic [39:0] ext;
    ext = {8'b0, addr} >> (alen * 8);
    d = dev | ((ovf && (op == 2'd1 || op == 2'd2)) ? (ext[6:0] & mask) : 7'd0);
    push(2'd0, 8'h00, 0);
    if (op == 2'd0 || op == 2'd3) begin
      push(2'd2, {d, 1'b0}, 0); e_nod = nb[w]; w++;
    end else begin
      if (op == 2'd2 || alen > 0) begin
        push(2'd2, {d, 1'b0}, 0);
        if (nb[w]) begin e_nod = 1; stop_now = 1; end
        w++;
        for (int i = alen - 1; i >= 0 && !stop_now; i--) begin
          push(2'd2, 8'(addr >> (i * 8)), 0);
          if (nb[w]) begin e_an = 1; stop_now = 1; end
          w++;
        end
      end
      if (!stop_now && op == 2'd2) begin
        for (int i = 0; i < len; i++) begin
          push(2'd2, 8'(8'h30 + i), 0);
          if (nb[w]) e_f++;
          w++;
        end
      end
      if (!stop_now && op == 2'd1) begin
        if (alen > 0) begin
          if (!rep) push(2'd1, 8'h00, 0);
          push(2'd0, 8'h00, 0);
        end
        push(2'd2, {d, 1'b1}, 0); w++;
        for (int i = 0; i < len; i++) begin
          push(2'd3, 8'h00, (i == len - 1));
          rdx_q.push_back(8'(8'hA0 + i));
        end
      end
    end
    push(2'd1, 8'h00, 0);

    @(negedge clk);
    nack_bits = nb; wcount = 0; rcount = 0;
    wr_q.delete();
    if (op == 2'd2) for (int i = 0; i < len; i++) wr_q.push_back(8'(8'h30 + i));
    wr_valid = wr_q.size() > 0;
    wr_data = wr_valid ? wr_q[0] : 8'h00;
    req_op = op; req_dev = dev; req_addr = addr; req_alen = 3'(alen); req_len = 8'(len);
    cfg_rep_start = rep; cfg_ovf_en = ovf; cfg_ovf_mask = mask;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R11", {tag, " busy after accept"}, int'(busy), 1);
    while (!done) begin
      @(negedge clk);
      k++;
      if (intrude && k == 3) begin
        chk(busy == 1, "R11", {tag, " busy mid-transaction"}, int'(busy), 1);
        req_op = 2'd0; req_dev = 7'h22; req_valid = 1;
      end
      if (intrude && k == 4) req_valid = 0;
    end
    chk(busy == 0, "R10", {tag, " busy low at done"}, int'(busy), 0);
    chk(st_nodev == e_nod, "R1/R2", {tag, " st_nodev"}, int'(st_nodev), int'(e_nod));
    chk(st_anack == e_an, "R4", {tag, " st_anack"}, int'(st_anack), int'(e_an));
    chk(st_fails == 8'(e_f), "R9", {tag, " st_fails"}, int'(st_fails), e_f);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", {tag, " commands left unissued"}, exp_q.size(), 0);
    chk(rdx_q.size() == 0, "R12", {tag, " read bytes missing"}, rdx_q.size(), 0);
    chk(st_nodev == e_nod && st_fails == 8'(e_f), "R10", {tag, " status held"}, int'(st_fails), e_f);
    exp_q.delete(); rdx_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cmd_valid == 0 && done == 0 && rd_valid == 0, "R11", "reset state",
        int'({busy, cmd_valid, done, rd_valid}), 0);
    // R1 probe present / absent
    run(2'd0, 7'h50, 0, 0, 0, 0, 1, 7'h7F, 32'h0, 0, "R1 probe present");
    run(2'd0, 7'h50, 0, 0, 0, 0, 0, 7'h00, 32'h1, 0, "R1 probe absent");
    // R3 R9 write, clean
    run(2'd2, 7'h50, 32'h1234, 2, 3, 0, 0, 7'h00, 32'h0, 0, "R3 write alen2");
    // R9 payload nacks counted
    run(2'd2, 7'h50, 32'h1234, 2, 4, 0, 0, 7'h00, (32'h1 << 3) | (32'h1 << 5), 0, "R9 data nacks");
    // R2 write target absent
    run(2'd2, 7'h51, 32'h1234, 2, 3, 0, 0, 7'h00, 32'h1, 0, "R2 write nodev");
    // R4 second address byte refused
    run(2'd2, 7'h50, 32'h1234, 2, 3, 0, 0, 7'h00, 32'h1 << 2, 0, "R4 write anack");
    // R5 R7 read stop-start
    run(2'd1, 7'h50, 32'hABCD, 2, 3, 0, 0, 7'h00, 32'h0, 0, "R5 read stop-start");
    // R5 repeated start
    run(2'd1, 7'h50, 32'h0042, 1, 2, 1, 0, 7'h00, 32'h0, 0, "R5 read rep-start");
    // R6 no address phase
    run(2'd1, 7'h48, 32'h0, 0, 2, 0, 0, 7'h00, 32'h0, 0, "R6 read alen0");
    // R2 read target absent
    run(2'd1, 7'h50, 32'h0010, 1, 2, 0, 0, 7'h00, 32'h1, 0, "R2 read nodev");
    // R4 read address refused
    run(2'd1, 7'h50, 32'h0010, 1, 2, 0, 0, 7'h00, 32'h1 << 1, 0, "R4 read anack");
    // R8 overflow folding
    run(2'd1, 7'h50, 32'h0305, 1, 1, 0, 1, 7'h03, 32'h0, 0, "R8 overflow fold");
    run(2'd2, 7'h50, 32'h0000_0707, 1, 1, 0, 1, 7'h06, 32'h0, 0, "R8 overflow write");
    // R3 four-byte address, nothing to fold
    run(2'd2, 7'h50, 32'h11223344, 4, 1, 0, 1, 7'h7F, 32'h0, 0, "R3 alen4");
    // R9 zero-length write
    run(2'd2, 7'h50, 32'h0009, 1, 0, 0, 0, 7'h00, 32'h0, 0, "R9 len0 write");
    // R11 request while busy ignored
    run(2'd2, 7'h50, 32'h0077, 1, 3, 0, 0, 7'h00, 32'h0, 1, "R11 busy ignore");
    summary();
    $finish;
  end
endmodule